// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's complement operands of equal width W. It uses one adder over a number of clock cycles. A single-cycle `start` pulse captures both operands while the block is idle. The block then consumes the multiplier two bits per cycle. In each cycle it forms a signed digit from three overlapping multiplier bits, adds the matching multiple of the multiplicand to the upper half of an accumulator, and shifts the whole accumulator right by two places, copying the sign into the vacated bits.

The block raises `busy` while it works. When it finishes, it drives the 2W-bit product and pulses `done` for one cycle. The product stays on the output until the next result replaces it. An odd W is sign-extended by one bit inside the block, so the step count is always half of an even width.

Top module: `booth_seq_mult`

## Requirements
- R1: The product equals the exact signed 2W-bit value of `mcand` times `mplier` captured at the accepted start. Examples: 3×29=87, -3×29=-87, -3×-29=87, 25×-35=-875.
- R2: Each step reads the multiplier triplet {bit i+1, bit i, bit i-1}, where the bit below the LSB is 0. The step adds these multiples of the multiplicand: 011 adds +2M; 001 and 010 add +M; 000 and 111 add nothing; 101 and 110 add -M; 100 adds -2M. Alternating and block-patterned multipliers (0x55, 0xAA, 0x33, 0xCC, 0x0F, 0xF0) therefore give exact products.
- R3: `done` goes high exactly ceil(W/2) clock edges after the edge that accepts `start`. For W=8 this is 4 edges.
- R4: A `start` that arrives while `busy` is high is ignored. It changes neither the pending result nor the number of `done` pulses.
- R5: `busy` is high from the edge after an accepted start until the edge that raises `done`. `busy` and `done` are never high together.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: `product` changes only in the cycle where `done` is high, and otherwise holds its last value.
- R8: Extreme operands give exact results. Examples: -128×-128=16384, -128×127=-16256, 127×127=16129 (W=8).
- R9: While reset is active and after it releases, `busy`=0, `done`=0 and `product`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; taken only when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when the product is new |
| product | output | 2W | Signed product, held between results |

## Verification
The assertions assume that `start` is a plain level sampled at the clock edge. They assume that operands matter only at the edge that accepts `start`. They also assume that reset is the only way to abort a multiply.

The stimulus raises `start` for one cycle while the block is idle, holds the operands steady for that edge, and changes them freely afterwards. The one deliberate exception is a burst of `start` with different operands during a busy window, which checks that such requests are dropped. Operands cover the full signed range, including both extremes, so the accumulator headroom is exercised at its limit.

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic signed [W-1:0]   mcand,
  input  logic signed [W-1:0]   mplier,
  output logic                  busy,
  output logic                  done,
  output logic signed [2*W-1:0] product
);
  localparam int EW    = W + (W % 2);
  localparam int STEPS = EW / 2;
  localparam int HW    = EW + 2;
  localparam int CW    = $clog2(STEPS + 1);

  logic signed [HW-1:0] hi, m_q, addend;
  logic [EW-1:0]        lo;
  logic                 xprev;
  logic [CW-1:0]        cnt;

  wire [2:0] trip = {lo[1:0], xprev};

  always_comb begin
    case (trip)
      3'b001, 3'b010: addend = m_q;
      3'b011:         addend = m_q <<< 1;
      3'b100:         addend = -(m_q <<< 1);
      3'b101, 3'b110: addend = -m_q;
      default:        addend = '0;
    endcase
  end

  wire signed [HW-1:0]    sum     = hi + addend;
  wire signed [HW+EW-1:0] shifted = $signed({sum, lo}) >>> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi      <= '0;
      lo      <= '0;
      m_q     <= '0;
      xprev   <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          hi    <= '0;
          lo    <= EW'(mplier);
          m_q   <= HW'(mcand);
          xprev <= 1'b0;
          cnt   <= CW'(STEPS);
          busy  <= 1'b1;
        end
      end else begin
        hi    <= shifted[HW+EW-1:EW];
        lo    <= shifted[EW-1:0];
        xprev <= lo[1];
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= shifted[2*W-1:0];
        end
      end
    end
  end

  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_busy_ends_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

  assert_start_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start) && !$past(busy));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(STEPS));
endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
  localparam int W     = 8;
  localparam int STEPS = (W + 1) / 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic signed [W-1:0]   mcand = '0;
  logic signed [W-1:0]   mplier = '0;
  logic                  busy, done;
  logic signed [2*W-1:0] product;

  booth_seq_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic signed [2*W-1:0] exp_q[$];
  string                 tag_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done pulse", product, 0);
      end else begin
        logic signed [2*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, product, e);
      end
    end
  end

  task automatic run_op(input logic signed [W-1:0] a, input logic signed [W-1:0] b, input string tag);
    logic signed [2*W-1:0] e;
    logic signed [2*W-1:0] held;
    int cnt;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = a * b;
    mcand = a; mplier = b; start = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    mcand = $urandom; mplier = $urandom;
    check(busy == 1'b1, "R5 busy after start", busy, 1);
    cnt = 0;
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == STEPS, "R3 latency", cnt, STEPS);
    check(busy == 1'b0, "R5 busy low with done", busy, 0);
    held = product;
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", done, 0);
    check(product == held, "R7 product held", product, held);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic signed [W-1:0] corners [8];
    logic [W-1:0] pats [6];
    corners = '{-8'sd128, -8'sd127, -8'sd2, -8'sd1, 8'sd0, 8'sd1, 8'sd2, 8'sd127};
    pats    = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};

    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(product == '0, "R9 reset product", product, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {busy, done}, 0);
    check(product == '0, "R9 product after reset", product, 0);

    run_op(8'sd3,   8'sd29,  "R1 3*29");
    run_op(-8'sd3,  8'sd29,  "R1 -3*29");
    run_op(-8'sd3,  -8'sd29, "R1 -3*-29");
    run_op(8'sd25,  -8'sd35, "R1 25*-35");

    foreach (pats[i]) begin
      run_op(8'sd37, pats[i], "R2 triplet pattern");
      run_op(-8'sd128, pats[i], "R2 triplet pattern extreme");
    end

    foreach (corners[i])
      foreach (corners[j])
        run_op(corners[i], corners[j], "R8 corner pair");

    // R4: start requests during busy are dropped
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand = 8'sd7; mplier = 8'sd9; start = 1'b1;
    exp_q.push_back(16'sd63); tag_q.push_back("R4 first operands kept");
    @(negedge clk);
    mcand = -8'sd100; mplier = 8'sd55;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R4 no extra done", done, 0);
      check(product == 16'sd63, "R7 hold while idle", product, 63);
      mcand = $urandom; mplier = $urandom;
    end

    for (int k = 0; k < 200; k++) begin
      logic signed [W-1:0] a, b;
      a = $urandom; b = $urandom;
      run_op(a, b, "R1 random pair");
    end

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule